// File: doc/BRIEF.md
# Slice-Based Coincidence Pairing Unit

This block takes a stream of single detector hits and turns it into a stream of coincident pairs. Each single carries the identifier of the crystal that was struck, a fine arrival time stamp and a measured energy. The energy is first checked against a programmable acceptance band centred on the expected photon energy. Singles outside the band are dropped and counted. The accepted singles are then gathered into time slices of programmable length. When a slice closes, every stored single is compared with every other single in the same slice. Two singles from different crystals whose stamps lie within a short programmable coincidence window form a pair, provided that neither of them matches any other single.

A slice opens with the first accepted single and closes when an accepted single arrives whose stamp lies at least one slice length after the opening stamp. That closing single becomes the first member of the next slice. Time stamps on the input must never decrease. While a closed slice is being resolved, the input is held off. Each emitted pair lists the earlier-arriving single first and carries the signed stamp difference, second minus first. A single with two or more partners is counted as a multiple, and no pair that involves it, or a partner of it, is emitted.

Both streams use valid/ready handshakes and a transfer occurs on a clock edge where both are high. The upstream side must hold `in_valid` and its data until `in_ready` is seen high. The unit holds `pair_valid` and every pair field steady until `pair_ready` is seen high, so downstream may apply back-pressure for any number of cycles. Configuration pins are plain levels and should only change while the unit is idle.

Top module: `coincidence_pairer`

## Requirements
- R1: A single whose energy is below `cfg_energy_lo` or above `cfg_energy_hi` is accepted, then dropped without entering any slice. Each such single increments `cnt_energy_reject` by one. Both bounds are inclusive, so a single at either bound is kept.
- R2: The first kept single opens a slice. A kept single whose stamp minus the slice's opening stamp is at least `cfg_slice_len` closes that slice and opens the next one. Singles in different slices are never paired, however close their stamps are.
- R3: Two singles of one slice pair when their stamps differ by at most `cfg_window` and each has the other as its only match. A stamp difference of `cfg_window` plus one does not pair.
- R4: A single that matches two or more singles of its slice increments `cnt_multiple` by one. No pair is emitted for that single or for any single that matches it.
- R5: Two singles with the same crystal identifier never match.
- R6: In a pair, the `pair_a_*` fields hold the single that arrived first and the `pair_b_*` fields hold the other. `pair_dt` is the signed difference b stamp minus a stamp, TS_W+1 bits wide.
- R7: A slice stores at most DEPTH (16) singles. A kept single that stays inside a full slice is dropped and increments `cnt_overflow`.
- R8: While `pair_valid` is high and `pair_ready` is low, `pair_valid` and all pair fields hold. `in_ready` is low whenever a pair is offered.
- R9: The pairs of a slice leave in order of the arrival position of their first member. Slices leave in the order in which they closed.
- R10: After reset `in_ready` is high, `pair_valid` is low and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slice_len | input | TS_W | Slice length in stamp units |
| cfg_window | input | TS_W | Largest stamp difference that still pairs |
| cfg_energy_lo | input | EN_W | Lowest accepted energy (inclusive) |
| cfg_energy_hi | input | EN_W | Highest accepted energy (inclusive) |
| in_valid | input | 1 | Single offered |
| in_ready | output | 1 | Unit takes the offered single |
| in_crystal | input | CRY_W | Crystal identifier of the single |
| in_time | input | TS_W | Arrival stamp, never decreasing |
| in_energy | input | EN_W | Measured energy |
| pair_valid | output | 1 | Pair offered |
| pair_ready | input | 1 | Downstream takes the pair |
| pair_a_crystal | output | CRY_W | Crystal of the first-arrived single |
| pair_a_time | output | TS_W | Stamp of the first-arrived single |
| pair_a_energy | output | EN_W | Energy of the first-arrived single |
| pair_b_crystal | output | CRY_W | Crystal of the second single |
| pair_b_time | output | TS_W | Stamp of the second single |
| pair_b_energy | output | EN_W | Energy of the second single |
| pair_dt | output | TS_W+1 | Signed stamp difference, b minus a |
| cnt_energy_reject | output | CNT_W | Singles dropped by the energy band |
| cnt_overflow | output | CNT_W | Singles dropped by a full slice |
| cnt_multiple | output | CNT_W | Singles found with two or more matches |

## Verification
The pairing function is first tried with directed slices. One slice holds an isolated pair. Others place a pair exactly at the window and one step past it, give two singles the same crystal, or form a three-hit chain and a tight triple. Together these separate a correct window comparison, crystal exclusion and multiples rule from off-by-one and over-eager variants. Further slices put a near pair across a slice boundary, test the energy band at and just past both bounds, overfill a slice by two, and hold three pairs under random back-pressure. These show whether the slice boundary, band edges, storage limit, output order and output hold are right. A long random stream with clustered stamps and a few crystals then drives every rule at once against the bench's own model.

// File: rtl/cp_pkg.sv
package cp_pkg;
  // Phases of the pairing controller
  typedef enum logic [1:0] {
    PH_GATHER  = 2'd0,  // taking singles into the open slice
    PH_SCAN    = 2'd1,  // counting matches of each stored single
    PH_EMIT    = 2'd2   // offering mutual sole pairs downstream
  } cp_phase_e;
endpackage

// File: rtl/cp_energy_gate.sv
module cp_energy_gate #(
  parameter int EN_W = 12
) (
  input  logic [EN_W-1:0] energy,
  input  logic [EN_W-1:0] bound_lo,
  input  logic [EN_W-1:0] bound_hi,
  output logic            in_band
);
  // Inclusive acceptance band
  assign in_band = (energy >= bound_lo) && (energy <= bound_hi);
endmodule

// File: rtl/cp_slice_store.sv
module cp_slice_store #(
  parameter int DEPTH = 16,
  parameter int CRY_W = 10,
  parameter int TS_W  = 24,
  parameter int EN_W  = 12,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [CRY_W-1:0]       wr_crystal,
  input  logic [TS_W-1:0]        wr_time,
  input  logic [EN_W-1:0]        wr_energy,
  output logic [DEPTH*CRY_W-1:0] rd_crystal,
  output logic [DEPTH*TS_W-1:0]  rd_time,
  output logic [DEPTH*EN_W-1:0]  rd_energy
);
  logic [CRY_W-1:0] mem_cry [DEPTH];
  logic [TS_W-1:0]  mem_tim [DEPTH];
  logic [EN_W-1:0]  mem_en  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        mem_cry[k] <= '0;
        mem_tim[k] <= '0;
        mem_en[k]  <= '0;
      end
    end else if (wr_en) begin
      mem_cry[wr_idx] <= wr_crystal;
      mem_tim[wr_idx] <= wr_time;
      mem_en[wr_idx]  <= wr_energy;
    end
  end

  // Every slot is visible at once for the parallel match row
  for (genvar k = 0; k < DEPTH; k++) begin : g_flat
    assign rd_crystal[k*CRY_W +: CRY_W] = mem_cry[k];
    assign rd_time[k*TS_W +: TS_W]      = mem_tim[k];
    assign rd_energy[k*EN_W +: EN_W]    = mem_en[k];
  end
endmodule

// File: rtl/cp_match_row.sv
module cp_match_row #(
  parameter int DEPTH = 16,
  parameter int CRY_W = 10,
  parameter int TS_W  = 24,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int N_W   = $clog2(DEPTH + 1)
) (
  input  logic [IDX_W-1:0]       probe_idx,
  input  logic [CRY_W-1:0]       probe_crystal,
  input  logic [TS_W-1:0]        probe_time,
  input  logic [DEPTH*CRY_W-1:0] all_crystal,
  input  logic [DEPTH*TS_W-1:0]  all_time,
  input  logic [N_W-1:0]         fill,
  input  logic [TS_W-1:0]        window,
  output logic [DEPTH-1:0]       hit
);
  // One comparator column per slot, all against the probe single
  for (genvar k = 0; k < DEPTH; k++) begin : g_col
    localparam logic [N_W-1:0]   SLOT_N = N_W'(k);
    localparam logic [IDX_W-1:0] SLOT_I = IDX_W'(k);
    logic [CRY_W-1:0] c_k;
    logic [TS_W-1:0]  t_k;
    logic [TS_W-1:0]  gap;
    assign c_k = all_crystal[k*CRY_W +: CRY_W];
    assign t_k = all_time[k*TS_W +: TS_W];
    assign gap = (t_k >= probe_time) ? (t_k - probe_time) : (probe_time - t_k);
    assign hit[k] = (SLOT_N < fill) && (SLOT_I != probe_idx) &&
                    (c_k != probe_crystal) && (gap <= window);
  end
endmodule

// File: rtl/coincidence_pairer.sv
module coincidence_pairer
  import cp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CRY_W = 10,
  parameter int TS_W  = 24,
  parameter int EN_W  = 12,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        cfg_slice_len,
  input  logic [TS_W-1:0]        cfg_window,
  input  logic [EN_W-1:0]        cfg_energy_lo,
  input  logic [EN_W-1:0]        cfg_energy_hi,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CRY_W-1:0]       in_crystal,
  input  logic [TS_W-1:0]        in_time,
  input  logic [EN_W-1:0]        in_energy,
  output logic                   pair_valid,
  input  logic                   pair_ready,
  output logic [CRY_W-1:0]       pair_a_crystal,
  output logic [TS_W-1:0]        pair_a_time,
  output logic [EN_W-1:0]        pair_a_energy,
  output logic [CRY_W-1:0]       pair_b_crystal,
  output logic [TS_W-1:0]        pair_b_time,
  output logic [EN_W-1:0]        pair_b_energy,
  output logic signed [TS_W:0]   pair_dt,
  output logic [CNT_W-1:0]       cnt_energy_reject,
  output logic [CNT_W-1:0]       cnt_overflow,
  output logic [CNT_W-1:0]       cnt_multiple
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int N_W   = $clog2(DEPTH + 1);
  localparam logic [N_W-1:0] FILL_MAX = N_W'(DEPTH);
  localparam logic [N_W-1:0] FILL_ONE = N_W'(1);

  cp_phase_e        phase;
  logic [N_W-1:0]   fill;
  logic [TS_W-1:0]  slice_open;
  logic [IDX_W-1:0] cur;
  logic [CRY_W-1:0] hold_cry;
  logic [TS_W-1:0]  hold_tim;
  logic [EN_W-1:0]  hold_en;
  logic [DEPTH-1:0] sole;
  logic [IDX_W-1:0] mate [DEPTH];

  // ---------------- intake side ----------------
  logic in_band;
  logic take;
  logic closes;
  logic [TS_W-1:0] elapsed;

  cp_energy_gate #(.EN_W(EN_W)) u_gate (
    .energy   (in_energy),
    .bound_lo (cfg_energy_lo),
    .bound_hi (cfg_energy_hi),
    .in_band  (in_band)
  );

  assign in_ready = (phase == PH_GATHER);
  assign take     = in_valid && in_ready;
  assign elapsed  = in_time - slice_open;
  assign closes   = (fill != '0) && (elapsed >= cfg_slice_len);

  // ---------------- slice storage ----------------
  logic                   st_we;
  logic [IDX_W-1:0]       st_idx;
  logic [CRY_W-1:0]       st_cry;
  logic [TS_W-1:0]        st_tim;
  logic [EN_W-1:0]        st_en;
  logic [DEPTH*CRY_W-1:0] all_cry;
  logic [DEPTH*TS_W-1:0]  all_tim;
  logic [DEPTH*EN_W-1:0]  all_en;

  cp_slice_store #(
    .DEPTH(DEPTH), .CRY_W(CRY_W), .TS_W(TS_W), .EN_W(EN_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (st_we),
    .wr_idx     (st_idx),
    .wr_crystal (st_cry),
    .wr_time    (st_tim),
    .wr_energy  (st_en),
    .rd_crystal (all_cry),
    .rd_time    (all_tim),
    .rd_energy  (all_en)
  );

  logic [CRY_W-1:0] s_cry [DEPTH];
  logic [TS_W-1:0]  s_tim [DEPTH];
  logic [EN_W-1:0]  s_en  [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_unpack
    assign s_cry[k] = all_cry[k*CRY_W +: CRY_W];
    assign s_tim[k] = all_tim[k*TS_W +: TS_W];
    assign s_en[k]  = all_en[k*EN_W +: EN_W];
  end

  // ---------------- match scan ----------------
  logic [DEPTH-1:0] hit;
  logic [N_W-1:0]   hit_cnt;
  logic [IDX_W-1:0] hit_idx;
  logic             last;

  cp_match_row #(
    .DEPTH(DEPTH), .CRY_W(CRY_W), .TS_W(TS_W)
  ) u_row (
    .probe_idx     (cur),
    .probe_crystal (s_cry[cur]),
    .probe_time    (s_tim[cur]),
    .all_crystal   (all_cry),
    .all_time      (all_tim),
    .fill          (fill),
    .window        (cfg_window),
    .hit           (hit)
  );

  assign hit_cnt = N_W'($countones(hit));

  always_comb begin
    hit_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit[k]) hit_idx = IDX_W'(k);
    end
  end

  assign last = (N_W'(cur) == (fill - FILL_ONE));

  // ---------------- emission ----------------
  logic [IDX_W-1:0] mate_cur;
  logic             emit_ok;
  logic             advance;

  assign mate_cur = mate[cur];
  assign emit_ok  = sole[cur] && (mate_cur > cur) && sole[mate_cur];
  assign advance  = (phase == PH_EMIT) && (!emit_ok || pair_ready);

  assign pair_valid     = (phase == PH_EMIT) && emit_ok;
  assign pair_a_crystal = s_cry[cur];
  assign pair_a_time    = s_tim[cur];
  assign pair_a_energy  = s_en[cur];
  assign pair_b_crystal = s_cry[mate_cur];
  assign pair_b_time    = s_tim[mate_cur];
  assign pair_b_energy  = s_en[mate_cur];
  assign pair_dt        = $signed({1'b0, s_tim[mate_cur]}) - $signed({1'b0, s_tim[cur]});

  // ---------------- storage write port ----------------
  logic restart;
  assign restart = advance && last;

  always_comb begin
    st_we  = 1'b0;
    st_idx = fill[IDX_W-1:0];
    st_cry = in_crystal;
    st_tim = in_time;
    st_en  = in_energy;
    if (phase == PH_GATHER) begin
      st_we = take && in_band &&
              ((fill == '0) || (!closes && (fill != FILL_MAX)));
    end else if (restart) begin
      st_we  = 1'b1;
      st_idx = '0;
      st_cry = hold_cry;
      st_tim = hold_tim;
      st_en  = hold_en;
    end
  end

  // ---------------- controller ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase             <= PH_GATHER;
      fill              <= '0;
      slice_open        <= '0;
      cur               <= '0;
      hold_cry          <= '0;
      hold_tim          <= '0;
      hold_en           <= '0;
      sole              <= '0;
      cnt_energy_reject <= '0;
      cnt_overflow      <= '0;
      cnt_multiple      <= '0;
      for (int k = 0; k < DEPTH; k++) mate[k] <= '0;
    end else begin
      unique case (phase)
        PH_GATHER: begin
          if (take) begin
            if (!in_band) begin
              cnt_energy_reject <= cnt_energy_reject + 1'b1;
            end else if (fill == '0) begin
              fill       <= FILL_ONE;
              slice_open <= in_time;
            end else if (closes) begin
              hold_cry <= in_crystal;
              hold_tim <= in_time;
              hold_en  <= in_energy;
              cur      <= '0;
              phase    <= PH_SCAN;
            end else if (fill == FILL_MAX) begin
              cnt_overflow <= cnt_overflow + 1'b1;
            end else begin
              fill <= fill + FILL_ONE;
            end
          end
        end
        PH_SCAN: begin
          sole[cur] <= (hit_cnt == FILL_ONE);
          mate[cur] <= hit_idx;
          if (hit_cnt > FILL_ONE) cnt_multiple <= cnt_multiple + 1'b1;
          if (last) begin
            cur   <= '0;
            phase <= PH_EMIT;
          end else begin
            cur <= cur + 1'b1;
          end
        end
        PH_EMIT: begin
          if (advance) begin
            if (last) begin
              fill       <= FILL_ONE;
              slice_open <= hold_tim;
              cur        <= '0;
              phase      <= PH_GATHER;
            end else begin
              cur <= cur + 1'b1;
            end
          end
        end
        default: phase <= PH_GATHER;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_ready |=> pair_valid && $stable(pair_a_time) &&
      $stable(pair_b_time) && $stable(pair_a_crystal) && $stable(pair_b_crystal)); // R8

  AST_NO_INTAKE_WHILE_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> !in_ready); // R8

  AST_DISTINCT_CRYSTAL: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> pair_a_crystal != pair_b_crystal); // R5

  AST_DT_WITHIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (pair_dt >= 0) && (pair_dt <= $signed({1'b0, cfg_window}))); // R3

  AST_REJECT_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_band |=> fill == $past(fill)); // R1

  AST_OVERFLOW_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_overflow != $past(cnt_overflow) |-> $past(fill) == FILL_MAX); // R7

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_MAX); // R7
endmodule

// File: tb/coincidence_pairer_test.sv
module coincidence_pairer_test;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 16;
  localparam int CRY_W  = 10;
  localparam int TS_W   = 24;
  localparam int EN_W   = 12;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TS_W-1:0]  cfg_slice_len = TS_W'(200);
  logic [TS_W-1:0]  cfg_window    = TS_W'(8);
  logic [EN_W-1:0]  cfg_energy_lo = EN_W'(400);
  logic [EN_W-1:0]  cfg_energy_hi = EN_W'(600);
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [CRY_W-1:0] in_crystal = '0;
  logic [TS_W-1:0]  in_time = '0;
  logic [EN_W-1:0]  in_energy = '0;
  logic             pair_valid;
  logic             pair_ready = 1'b0;
  logic [CRY_W-1:0] pa_c, pb_c;
  logic [TS_W-1:0]  pa_t, pb_t;
  logic [EN_W-1:0]  pa_e, pb_e;
  logic signed [TS_W:0] p_dt;
  logic [CNT_W-1:0] c_erej, c_ovf, c_mul;

  always #(CLK_NS/2) clk = ~clk;

  coincidence_pairer #(
    .DEPTH(DEPTH), .CRY_W(CRY_W), .TS_W(TS_W), .EN_W(EN_W), .CNT_W(CNT_W)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_slice_len(cfg_slice_len), .cfg_window(cfg_window),
    .cfg_energy_lo(cfg_energy_lo), .cfg_energy_hi(cfg_energy_hi),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_crystal(in_crystal), .in_time(in_time), .in_energy(in_energy),
    .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_a_crystal(pa_c), .pair_a_time(pa_t), .pair_a_energy(pa_e),
    .pair_b_crystal(pb_c), .pair_b_time(pb_t), .pair_b_energy(pb_e),
    .pair_dt(p_dt),
    .cnt_energy_reject(c_erej), .cnt_overflow(c_ovf), .cnt_multiple(c_mul)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int sl_cry[$];
  int sl_tim[$];
  int sl_en[$];
  int sl_start = 0;
  int ex_ac[$], ex_at[$], ex_ae[$], ex_bc[$], ex_bt[$], ex_be[$];
  int exp_erej = 0, exp_ovf = 0, exp_mul = 0;
  int pairs_seen = 0;

  task automatic model_resolve();
    int n;
    int cnt[DEPTH];
    int mt[DEPTH];
    n = sl_cry.size();
    for (int i = 0; i < n; i++) begin
      cnt[i] = 0;
      mt[i] = 0;
      for (int k = 0; k < n; k++) begin
        int gap;
        gap = sl_tim[k] - sl_tim[i];
        if (gap < 0) gap = -gap;
        if (k != i && sl_cry[k] != sl_cry[i] && gap <= int'(cfg_window)) begin
          cnt[i]++;
          mt[i] = k;
        end
      end
    end
    for (int i = 0; i < n; i++) if (cnt[i] >= 2) exp_mul++;
    for (int i = 0; i < n; i++) begin
      if (cnt[i] == 1 && mt[i] > i && cnt[mt[i]] == 1) begin
        ex_ac.push_back(sl_cry[i]); ex_at.push_back(sl_tim[i]); ex_ae.push_back(sl_en[i]);
        ex_bc.push_back(sl_cry[mt[i]]); ex_bt.push_back(sl_tim[mt[i]]); ex_be.push_back(sl_en[mt[i]]);
      end
    end
  endtask

  task automatic model_push(int cry, int tim, int en);
    if (en < int'(cfg_energy_lo) || en > int'(cfg_energy_hi)) begin
      exp_erej++;
    end else if (sl_cry.size() == 0) begin
      sl_cry.push_back(cry); sl_tim.push_back(tim); sl_en.push_back(en);
      sl_start = tim;
    end else if (tim - sl_start >= int'(cfg_slice_len)) begin
      model_resolve();
      sl_cry.delete(); sl_tim.delete(); sl_en.delete();
      sl_cry.push_back(cry); sl_tim.push_back(tim); sl_en.push_back(en);
      sl_start = tim;
    end else if (sl_cry.size() == DEPTH) begin
      exp_ovf++;
    end else begin
      sl_cry.push_back(cry); sl_tim.push_back(tim); sl_en.push_back(en);
    end
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic send(int cry, int tim, int en);
    model_push(cry, tim, en);
    @(negedge clk);
    in_valid   = 1'b1;
    in_crystal = CRY_W'(cry);
    in_time    = TS_W'(tim);
    in_energy  = EN_W'(en);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (!(in_ready && ex_ac.size() == 0)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_counters(string tag);
    check(int'(c_erej) == exp_erej, "R1", {tag, " energy rejects"}, c_erej, exp_erej);
    check(int'(c_ovf) == exp_ovf, "R7", {tag, " overflow count"}, c_ovf, exp_ovf);
    check(int'(c_mul) == exp_mul, "R4", {tag, " multiples count"}, c_mul, exp_mul);
  endtask

  // ---------------- output side: ready pattern and per-clock compare ----------------
  int rdy_mode = 0;
  bit prev_stall = 0;
  logic [CRY_W-1:0] st_ac, st_bc;
  logic [TS_W-1:0]  st_at, st_bt;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_stall) begin
        check(pair_valid == 1'b1, "R8", "valid held under stall", pair_valid, 1);
        check(pa_t == st_at && pb_t == st_bt && pa_c == st_ac && pb_c == st_bc,
              "R8", "pair fields held under stall", pa_t, st_at);
      end
      if (pair_valid) check(in_ready == 1'b0, "R8", "intake closed during offer", in_ready, 0);
      pair_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      if (pair_valid && pair_ready) begin
        pairs_seen++;
        if (ex_ac.size() == 0) begin
          check(1'b0, "R3", "unexpected pair, first stamp", pa_t, -1);
        end else begin
          int eac, eat, eae, ebc, ebt, ebe;
          eac = ex_ac.pop_front(); eat = ex_at.pop_front(); eae = ex_ae.pop_front();
          ebc = ex_bc.pop_front(); ebt = ex_bt.pop_front(); ebe = ex_be.pop_front();
          check(int'(pa_t) == eat && int'(pa_c) == eac && int'(pa_e) == eae,
                "R9", "first member of pair (stamp)", pa_t, eat);
          check(int'(pb_t) == ebt && int'(pb_c) == ebc && int'(pb_e) == ebe,
                "R6", "second member of pair (stamp)", pb_t, ebt);
          check(int'(p_dt) == ebt - eat, "R6", "signed stamp difference", p_dt, ebt - eat);
        end
      end
      prev_stall = pair_valid && !pair_ready;
      st_ac = pa_c; st_bc = pb_c; st_at = pa_t; st_bt = pb_t;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_NS * 190000);
    if (!finished) begin
      finished = 1;
      check(1'b0, "R8", "watchdog, run completed", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  int base = 1000;
  int seen0;

  initial begin
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    check(pair_valid == 1'b0, "R10", "pair_valid after reset", pair_valid, 0);
    check(c_erej == '0 && c_ovf == '0 && c_mul == '0, "R10", "counters after reset",
          c_erej + c_ovf + c_mul, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: isolated pair, then a far single to close the slice
    seen0 = pairs_seen;
    send(1, base, 511); send(2, base + 5, 511); send(900, base + 500, 511);
    settle();
    check(pairs_seen - seen0 == 1, "R3", "isolated pair count", pairs_seen - seen0, 1);
    base += 1000;

    // R3: difference exactly the window pairs; window plus one does not
    seen0 = pairs_seen;
    send(3, base, 511); send(4, base + 8, 511); send(901, base + 300, 511);
    send(5, base + 600, 511); send(6, base + 609, 511); send(902, base + 900, 511);
    settle();
    check(pairs_seen - seen0 == 1, "R3", "window boundary pair count", pairs_seen - seen0, 1);
    base += 2000;

    // R5: same crystal never pairs
    seen0 = pairs_seen;
    send(7, base, 511); send(7, base + 3, 511); send(903, base + 500, 511);
    settle();
    check(pairs_seen - seen0 == 0, "R5", "same crystal pair count", pairs_seen - seen0, 0);
    base += 1000;

    // R4: chain gives one multiple; tight triple gives three
    seen0 = pairs_seen;
    send(10, base, 511); send(11, base + 6, 511); send(12, base + 12, 511);
    send(904, base + 500, 511);
    send(13, base + 1000, 511); send(14, base + 1002, 511); send(15, base + 1004, 511);
    send(905, base + 1500, 511);
    settle();
    check(pairs_seen - seen0 == 0, "R4", "pairs from multiples", pairs_seen - seen0, 0);
    check(int'(c_mul) == 4, "R4", "multiples after chain and triple", c_mul, 4);
    check_counters("multiples");
    base += 3000;

    // R1: energy band edges
    seen0 = pairs_seen;
    send(20, base, 399); send(21, base + 1, 601);
    send(22, base + 2, 400); send(23, base + 4, 600); send(906, base + 500, 511);
    settle();
    check(pairs_seen - seen0 == 1, "R1", "pair at band edges", pairs_seen - seen0, 1);
    check(int'(c_erej) == 2, "R1", "rejected outside band", c_erej, 2);
    base += 1000;

    // R7: eighteen singles in one slice
    for (int i = 0; i < 18; i++) send(100 + i, base + 10 * i, 511);
    send(907, base + 600, 511);
    settle();
    check(int'(c_ovf) == 2, "R7", "overflow drops", c_ovf, 2);
    check_counters("overflow");
    base += 1000;

    // R2: near singles on either side of a slice boundary
    seen0 = pairs_seen;
    send(30, base, 511); send(31, base + 195, 511); send(32, base + 200, 511);
    send(33, base + 204, 511); send(908, base + 700, 511);
    settle();
    check(pairs_seen - seen0 == 1, "R2", "pairs across slice boundary", pairs_seen - seen0, 1);
    base += 1000;

    // R8, R9: three pairs in one slice under back-pressure
    rdy_mode = 1;
    seen0 = pairs_seen;
    send(40, base, 511); send(41, base + 3, 511);
    send(42, base + 50, 511); send(43, base + 52, 511);
    send(44, base + 100, 511); send(45, base + 107, 511);
    send(909, base + 600, 511);
    settle();
    check(pairs_seen - seen0 == 3, "R9", "pairs under back-pressure", pairs_seen - seen0, 3);
    base += 1000;

    // Random stream with a different slice and window
    cfg_slice_len = TS_W'(120);
    cfg_window    = TS_W'(12);
    for (int i = 0; i < 400; i++) begin
      base += $urandom % 14;
      send($urandom % 8, base, 380 + ($urandom % 260));
    end
    base += 2000;
    send(910, base, 511);
    settle();
    check_counters("random R2 R3");
    check(ex_ac.size() == 0, "R9", "expected pairs left over", ex_ac.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule